// File: doc/BRIEF.md
# Multiplexed Eight-Digit Seven-Segment Display Driver

This block lights an eight-digit, common-anode seven-segment display by showing one digit at a time and stepping through all positions fast enough that the eye sees every digit lit together. Each position has a 6-bit descriptor in one packed input bus. A descriptor holds a hex nibble, a decimal-point flag and an enable flag.

A prescaler counts system clock cycles (100 MHz) and produces a one-cycle tick once per slot. The tick advances a digit index. The index selects the descriptor to show and drives the anode lines for that position. The selected nibble is decoded to a segment pattern. A digit whose enable flag is clear is blanked for its whole slot. The default slot is 100,000 cycles. That gives 1 ms per digit and a 125 Hz full-frame refresh.

Top module: `seg_mux_driver`

## Requirements
- R1: While rst_ni is low, the digit index and the prescaler are held at zero, so position 0 is selected.
- R2: The prescaler emits a single-cycle tick every TICK_CYCLES clock cycles. After reset is released, position 0 stays selected for exactly TICK_CYCLES rising edges.
- R3: Each tick moves the index up by one. After position NUM_DIGITS-1 it returns to 0. Without a tick the index holds.
- R4: All outputs are active low. At most one bit of an_o is low at a time. an_o[k] is low only while position k is selected and bit 5 (enable) of its descriptor is 1.
- R5: While the selected descriptor has bit 5 = 0, an_o is all ones, seg_o is all ones and dp_o is 1.
- R6: Bits 4:1 of the selected enabled descriptor are decoded onto seg_o, with seg_o[0] = segment a through seg_o[6] = g. The active-high patterns (g..a) are: 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71. seg_o is the bitwise inverse of the pattern.
- R7: dp_o is 0 exactly when the selected descriptor is enabled and its bit 0 is 1.
- R8: Descriptor k occupies digits_i[6k+5:6k]. The outputs follow changes on digits_i in the same cycle, without waiting for a new slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| digits_i | input | 6*NUM_DIGITS | Packed per-position descriptors {enable, nibble[3:0], point} |
| an_o | output | NUM_DIGITS | Anode selects, active low |
| seg_o | output | 7 | Segments a..g in bits 0..6, active low |
| dp_o | output | 1 | Decimal point, active low |

## Verification
The scan is tried in four ways:
- With every position enabled and holding a different nibble and point flag. This shows that the index order, the wrap after the last position and the descriptor-to-position mapping are correct.
- With all positions set to one nibble, swept through all sixteen values. This checks each decoder pattern separately from the scan.
- With only one position enabled. This separates blanking from anode selection, since seven of every eight slots must be dark.
- By measuring slot lengths and the first slot after reset. This pins the prescaler period and the reset alignment.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int DESC_W = 6;
  localparam int SEG_W  = 7;

  // bit 5 enable, bits 4:1 nibble, bit 0 point
  typedef struct packed {
    logic       en;
    logic [3:0] val;
    logic       dp;
  } digit_desc_t;

  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int TICK_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(TICK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == TERM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TERM);

  if (TICK_CYCLES > 1) begin : g_pulse_chk
    p_tick_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o);
  end
endmodule

// File: rtl/digit_index.sv
module digit_index #(
  parameter int NUM_DIGITS = 8,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DIGITS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= '0;
    else if (tick_i)  idx_o <= (idx_o == LAST) ? '0 : idx_o + 1'b1;
  end

  p_idx_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (idx_o == (($past(idx_o) == LAST) ? '0 : $past(idx_o) + 1'b1)));

  p_idx_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(idx_o));
endmodule

// File: rtl/an_decoder.sv
module an_decoder #(
  parameter int NUM_DIGITS = 8,
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1
) (
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  en_i,
  output logic [NUM_DIGITS-1:0] an_o
);
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_an
    assign an_o[k] = !(en_i && (idx_i == IDX_W'(k)));
  end
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import seg_pkg::*;
(
  input  logic [3:0] val_i,
  output seg_t       seg_n_o
);
  seg_t lit;

  // active-high, bit order g..a
  always_comb begin
    unique case (val_i)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end

  assign seg_n_o = ~lit;
endmodule

// File: rtl/seg_mux_driver.sv
module seg_mux_driver
  import seg_pkg::*;
#(
  parameter int NUM_DIGITS  = 8,
  parameter int TICK_CYCLES = 100000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_DIGITS*DESC_W-1:0] digits_i,
  output logic [NUM_DIGITS-1:0]        an_o,
  output logic [SEG_W-1:0]             seg_o,
  output logic                         dp_o
);
  localparam int IDX_W = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic             tick;
  logic [IDX_W-1:0] idx;
  digit_desc_t      desc [NUM_DIGITS];
  digit_desc_t      sel;
  seg_t             seg_n;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_desc
    assign desc[k] = digits_i[k*DESC_W +: DESC_W];
  end

  refresh_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  digit_index #(.NUM_DIGITS(NUM_DIGITS)) u_index (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .idx_o (idx)
  );

  assign sel = desc[idx];

  an_decoder #(.NUM_DIGITS(NUM_DIGITS)) u_an (
    .idx_i(idx),
    .en_i (sel.en),
    .an_o (an_o)
  );

  seg_decoder u_seg (
    .val_i  (sel.val),
    .seg_n_o(seg_n)
  );

  assign seg_o = sel.en ? seg_n : '1;
  assign dp_o  = !(sel.en && sel.dp);

  p_one_anode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~an_o));

  p_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel.en |-> (&an_o && &seg_o && dp_o));
endmodule

// File: tb/tb_seg_mux_driver.sv
module tb_seg_mux_driver;
  localparam int CLK_PERIOD = 10;
  localparam int ND   = 8;
  localparam int TICK = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [ND*6-1:0] digits_i = '0;
  logic [ND-1:0] an_o;
  logic [6:0]    seg_o;
  logic          dp_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  seg_mux_driver #(.NUM_DIGITS(ND), .TICK_CYCLES(TICK)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .digits_i(digits_i),
    .an_o(an_o), .seg_o(seg_o), .dp_o(dp_o)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] p;
    case (v)
      4'h0: p = 7'h3F; 4'h1: p = 7'h06; 4'h2: p = 7'h5B; 4'h3: p = 7'h4F;
      4'h4: p = 7'h66; 4'h5: p = 7'h6D; 4'h6: p = 7'h7D; 4'h7: p = 7'h07;
      4'h8: p = 7'h7F; 4'h9: p = 7'h6F; 4'hA: p = 7'h77; 4'hB: p = 7'h7C;
      4'hC: p = 7'h39; 4'hD: p = 7'h5E; 4'hE: p = 7'h79; default: p = 7'h71;
    endcase
    return ~p;
  endfunction

  function automatic logic [5:0] mk(input logic en, input logic [3:0] v, input logic dp);
    return {en, v, dp};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_all(input logic en, input logic [3:0] v, input logic dp);
    for (int k = 0; k < ND; k++) digits_i[k*6 +: 6] = mk(en, v, dp);
  endtask

  function automatic int low_pos(input logic [ND-1:0] a);
    for (int k = 0; k < ND; k++) if (!a[k]) return k;
    return -1;
  endfunction

  task automatic wait_boundary();
    logic [ND-1:0] prev;
    prev = an_o;
    do @(negedge clk_i); while (an_o == prev);
  endtask

  task automatic t_reset();
    set_all(1'b1, 4'h0, 1'b0);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(an_o == 8'hFE, "R1 reset selects position 0", an_o, 8'hFE);
    rst_ni = 1'b1;
    repeat (TICK - 1) @(negedge clk_i);
    chk(an_o == 8'hFE, "R2 first slot still position 0", an_o, 8'hFE);
    @(negedge clk_i);
    chk(an_o == 8'hFD, "R2 advance after TICK edges", an_o, 8'hFD);
  endtask

  task automatic t_period();
    set_all(1'b1, 4'h8, 1'b0);
    wait_boundary();
    for (int s = 0; s < 3; s++) begin
      int n;
      logic [ND-1:0] prev;
      n = 0;
      prev = an_o;
      do begin @(negedge clk_i); n++; end while (an_o == prev);
      chk(n == TICK, "R2 slot length", n, TICK);
    end
  endtask

  task automatic t_scan();
    int pos;
    for (int k = 0; k < ND; k++)
      digits_i[k*6 +: 6] = mk(1'b1, 4'((k + 3) % 16), k[0]);
    wait_boundary();
    pos = low_pos(an_o);
    for (int s = 0; s < ND + 2; s++) begin
      chk($countones(~an_o) == 1, "R4 single anode low", an_o, 0);
      chk(seg_o == exp_seg(4'((pos + 3) % 16)), "R6 R8 scan segments", seg_o, exp_seg(4'((pos + 3) % 16)));
      chk(dp_o == !pos[0], "R7 point per position", dp_o, !pos[0]);
      wait_boundary();
      chk(low_pos(an_o) == (pos + 1) % ND, "R3 index order and wrap", low_pos(an_o), (pos + 1) % ND);
      pos = low_pos(an_o);
    end
  endtask

  task automatic t_hex();
    for (int v = 0; v < 16; v++) begin
      set_all(1'b1, 4'(v), 1'b0);
      @(negedge clk_i);
      chk(seg_o == exp_seg(4'(v)), "R6 decode value", seg_o, exp_seg(4'(v)));
    end
    set_all(1'b1, 4'h1, 1'b1);
    @(negedge clk_i);
    chk(dp_o == 1'b0, "R7 point lit when enabled", dp_o, 0);
  endtask

  task automatic t_blank();
    int lit, bad;
    set_all(1'b0, 4'h8, 1'b1);
    @(negedge clk_i);
    chk(an_o == 8'hFF, "R5 disabled anodes high", an_o, 8'hFF);
    chk(seg_o == 7'h7F, "R5 disabled segments off", seg_o, 7'h7F);
    chk(dp_o == 1'b1, "R5 R7 disabled point off", dp_o, 1);
    digits_i[2*6 +: 6] = mk(1'b1, 4'h5, 1'b1);
    lit = 0; bad = 0;
    for (int c = 0; c < ND * TICK; c++) begin
      @(negedge clk_i);
      if (an_o != 8'hFF) begin
        lit++;
        if (an_o != 8'hFB || seg_o != exp_seg(4'h5) || dp_o != 1'b0) bad++;
      end else if (seg_o != 7'h7F || dp_o != 1'b1) bad++;
    end
    chk(lit == TICK, "R4 lone enabled position lit one slot", lit, TICK);
    chk(bad == 0, "R5 blank slots and lit slot content", bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_period();
    t_scan();
    t_hex();
    t_blank();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule